// File: doc/BRIEF.md
# Instruction Legality Constraint Checker

This block watches one 32-bit instruction word per cycle and decides whether it falls inside a restricted, permitted subset of a RISC-style instruction set. The word is cut into fixed bit fields (opcode, destination register, two source registers, a 3-bit function code and a 7-bit function code). Each instruction class first has a format rule. The rule is its opcode, and when register halving is on it also requires that every register field the class uses lies in the lower half of the register file. Each permitted instruction in the class then matches only if that format rule holds and its function constants are equal to the fixed values.

The per-class results come out as a flag vector, and their OR gives a single legal flag. A sticky violation flag records the first clock edge at which the presented word was not legal. It holds until reset. The block is used as an environment constraint or monitor next to a fetch or decode path. It restricts generated or observed traffic to a small, well-understood instruction mix that uses only half of the registers.

Top module: `instr_legal_chk`

## Requirements
- R1: Fields are fixed slices of the word: opcode [6:0], destination register [11:7], 3-bit function [14:12], first source [19:15], second source [24:20], 7-bit function [31:25].
- R2: Flag bit 1 (register-register ALU class) is 1 only when opcode = 7'b0110011, all three register fields are below 16, and either the 7-bit function is 0 with the 3-bit function one of 000, 100, 110, 111, or the 7-bit function is 7'b0100000 with the 3-bit function 000.
- R3: Flag bit 2 (register-immediate ALU class) is 1 only when opcode = 7'b0010011, destination and first source are below 16, and the 3-bit function is one of 000, 100, 110, 111. The immediate bits [31:20] have no effect.
- R4: Flag bit 3 (load class) is 1 only when opcode = 7'b0000011, destination and first source are below 16, and the 3-bit function is 000, 001 or 010.
- R5: Flag bit 0 (no-operation class) is 1 exactly when the word equals 32'h0000_0013. It has no format rule of its own, and the same word also sets bit 2.
- R6: With register halving on (default, 32 registers), a register field of 16 or more clears the flag of a class that uses that field. A field the class does not use as a register does not clear it.
- R7: The legal output is the OR of the four class flags, so any opcode other than the three listed gives all flags 0 and legal 0.
- R8: The violation flag is 0 during and after reset. It becomes 1 at the first rising clock edge where legal is 0 and reset is released, and it stays 1 until the next reset.
- R9: At most one of flag bits 1, 2 and 3 is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word under check |
| type_ok_o | output | 4 | Per-class legal flags: bit0 no-op, bit1 reg-reg, bit2 reg-imm, bit3 load |
| legal_o | output | 1 | Word belongs to the permitted subset |
| viol_o | output | 1 | Sticky flag: an illegal word was seen at a clock edge |

## Verification
On every cycle the assertions check the following. Each raised class flag agrees with its opcode and function constraints. A raised flag implies the upper register bits are clear. The three opcode classes never overlap. The no-op flag appears only for the exact no-op word. The violation flag sets after an illegal edge and never drops. Only the bench scenarios can show the other direction: that every permitted alternative of a multi-valued function field is accepted, that unused immediate bits are ignored, and that reset clears the sticky flag. The bench checks each of these against a reference model written separately from the RTL, using both directed words and random words.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int unsigned ILEN      = 32;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned NUM_TYPES = 4;

  localparam int unsigned T_NOP = 0;
  localparam int unsigned T_RR  = 1;
  localparam int unsigned T_RI  = 2;
  localparam int unsigned T_LD  = 3;

  localparam logic [6:0] OPC_RR = 7'b0110011;
  localparam logic [6:0] OPC_RI = 7'b0010011;
  localparam logic [6:0] OPC_LD = 7'b0000011;
  localparam logic [6:0] F7_ALT = 7'b0100000;

  typedef struct packed {
    logic [6:0]       opc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [2:0]       f3;
    logic [6:0]       f7;
  } fields_t;
endpackage

// File: rtl/ilc_field_split.sv
module ilc_field_split
  import ilc_pkg::*;
(
  input  logic [ILEN-1:0] word_i,
  output fields_t         fields_o
);
  assign fields_o.opc = word_i[6:0];
  assign fields_o.rd  = word_i[11:7];
  assign fields_o.f3  = word_i[14:12];
  assign fields_o.rs1 = word_i[19:15];
  assign fields_o.rs2 = word_i[24:20];
  assign fields_o.f7  = word_i[31:25];
endmodule

// File: rtl/ilc_reg_gate.sv
module ilc_reg_gate
  import ilc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter bit          HALF_EN  = 1'b1,
  parameter int unsigned N_USED   = 2
) (
  input  logic [N_USED-1:0][REG_W-1:0] regs_i,
  output logic                         ok_o
);
  localparam logic [REG_W:0] HALF_LIM = (REG_W+1)'(NUM_REGS / 2);

  if (HALF_EN) begin : g_half
    logic [N_USED-1:0] below;
    for (genvar g = 0; g < N_USED; g++) begin : g_reg
      assign below[g] = {1'b0, regs_i[g]} < HALF_LIM;
    end
    assign ok_o = &below;
  end else begin : g_full
    logic unused_regs;
    assign unused_regs = ^regs_i;
    assign ok_o        = 1'b1;
  end
endmodule

// File: rtl/ilc_type_match.sv
module ilc_type_match
  import ilc_pkg::*;
(
  input  fields_t                fields_i,
  input  logic                   rr_regs_ok_i,
  input  logic                   ri_regs_ok_i,
  input  logic                   ld_regs_ok_i,
  output logic [NUM_TYPES-1:0]   type_ok_o
);
  logic fmt_rr, fmt_ri, fmt_ld;
  logic f3_logic, f3_zero;
  logic m_add, m_sub, m_log, m_addi, m_logi, m_ld, m_nop;

  // format rule: opcode plus register-half constraint
  assign fmt_rr = (fields_i.opc == OPC_RR) & rr_regs_ok_i;
  assign fmt_ri = (fields_i.opc == OPC_RI) & ri_regs_ok_i;
  assign fmt_ld = (fields_i.opc == OPC_LD) & ld_regs_ok_i;

  assign f3_zero  = fields_i.f3 == 3'b000;
  assign f3_logic = (fields_i.f3 == 3'b100) | (fields_i.f3 == 3'b110) |
                    (fields_i.f3 == 3'b111);

  assign m_add  = fmt_rr & f3_zero  & (fields_i.f7 == 7'd0);
  assign m_sub  = fmt_rr & f3_zero  & (fields_i.f7 == F7_ALT);
  assign m_log  = fmt_rr & f3_logic & (fields_i.f7 == 7'd0);
  assign m_addi = fmt_ri & f3_zero;
  assign m_logi = fmt_ri & f3_logic;
  assign m_ld   = fmt_ld & ((fields_i.f3 == 3'b000) | (fields_i.f3 == 3'b001) |
                            (fields_i.f3 == 3'b010));

  // no-op class: field equalities only, no format term
  assign m_nop = (fields_i.opc == OPC_RI) & (fields_i.rd == '0) & f3_zero &
                 (fields_i.rs1 == '0) & (fields_i.rs2 == '0) & (fields_i.f7 == '0);

  assign type_ok_o[T_NOP] = m_nop;
  assign type_ok_o[T_RR]  = m_add | m_sub | m_log;
  assign type_ok_o[T_RI]  = m_addi | m_logi;
  assign type_ok_o[T_LD]  = m_ld;
endmodule

// File: rtl/instr_legal_chk.sv
module instr_legal_chk
  import ilc_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 32,
  parameter bit          HALF_REGS_EN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ILEN-1:0]      instr_i,
  output logic [NUM_TYPES-1:0] type_ok_o,
  output logic                 legal_o,
  output logic                 viol_o
);
  fields_t f;
  logic    rr_regs_ok, ri_regs_ok, ld_regs_ok;
  logic    viol_q;

  ilc_field_split u_split (.word_i(instr_i), .fields_o(f));

  ilc_reg_gate #(.NUM_REGS(NUM_REGS), .HALF_EN(HALF_REGS_EN), .N_USED(3)) u_rr_gate (
    .regs_i({f.rd, f.rs1, f.rs2}), .ok_o(rr_regs_ok));
  ilc_reg_gate #(.NUM_REGS(NUM_REGS), .HALF_EN(HALF_REGS_EN), .N_USED(2)) u_ri_gate (
    .regs_i({f.rd, f.rs1}), .ok_o(ri_regs_ok));
  ilc_reg_gate #(.NUM_REGS(NUM_REGS), .HALF_EN(HALF_REGS_EN), .N_USED(2)) u_ld_gate (
    .regs_i({f.rd, f.rs1}), .ok_o(ld_regs_ok));

  ilc_type_match u_match (
    .fields_i    (f),
    .rr_regs_ok_i(rr_regs_ok),
    .ri_regs_ok_i(ri_regs_ok),
    .ld_regs_ok_i(ld_regs_ok),
    .type_ok_o   (type_ok_o)
  );

  assign legal_o = |type_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       viol_q <= 1'b0;
    else if (!legal_o) viol_q <= 1'b1;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/instr_legal_chk_sva.sv
module instr_legal_chk_sva #(
  parameter int unsigned NUM_REGS = 32,
  parameter bit          HALF_EN  = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic [3:0]  type_ok_o,
  input logic        legal_o,
  input logic        viol_o
);
  localparam bit CHK_HALF = HALF_EN && (NUM_REGS == 32);

  a_r2_rr_constants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_ok_o[1] |-> instr_i[6:0] == 7'b0110011 &&
      (instr_i[31:25] == 7'd0 || (instr_i[31:25] == 7'b0100000 && instr_i[14:12] == 3'd0)));

  a_r3_ri_f3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_ok_o[2] |-> instr_i[6:0] == 7'b0010011 && instr_i[14:12] != 3'b001 &&
      instr_i[14:12] != 3'b010 && instr_i[14:12] != 3'b011 && instr_i[14:12] != 3'b101);

  a_r4_load_f3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_ok_o[3] |-> instr_i[6:0] == 7'b0000011 && instr_i[14:12] <= 3'd2);

  a_r5_nop_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_ok_o[0] |-> instr_i == 32'h0000_0013 && type_ok_o[2]);

  a_r6_half_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CHK_HALF && (|type_ok_o[3:1]) |-> !instr_i[11] && !instr_i[19] &&
      (!type_ok_o[1] || !instr_i[24]));

  a_r7_unknown_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] != 7'b0110011 && instr_i[6:0] != 7'b0010011 &&
     instr_i[6:0] != 7'b0000011) |-> !legal_o);

  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_o |=> viol_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(type_ok_o[3:1]));
endmodule

bind instr_legal_chk instr_legal_chk_sva #(.NUM_REGS(NUM_REGS), .HALF_EN(HALF_REGS_EN)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .instr_i  (instr_i),
  .type_ok_o(type_ok_o),
  .legal_o  (legal_o),
  .viol_o   (viol_o)
);

// File: tb/instr_legal_chk_tb_top.sv
module instr_legal_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = 32'h0000_0013;
  logic [3:0]  type_ok_o;
  logic        legal_o, viol_o;

  int total = 0;
  int bad   = 0;
  logic exp_viol = 1'b0;

  always #5 clk_i = ~clk_i;

  instr_legal_chk dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
    .type_ok_o(type_ok_o), .legal_o(legal_o), .viol_o(viol_o)
  );

  // R1 field layout
  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  function automatic logic [3:0] exp_types(input logic [31:0] w);
    logic [3:0] r;
    logic lo_rd, lo_s1, lo_s2;
    r = 4'b0;
    lo_rd = !w[11]; lo_s1 = !w[19]; lo_s2 = !w[24];
    case (w[6:0])
      7'h33: if (lo_rd && lo_s1 && lo_s2)
        case ({w[31:25], w[14:12]})
          {7'h00, 3'd0}, {7'h00, 3'd4}, {7'h00, 3'd6},
          {7'h00, 3'd7}, {7'h20, 3'd0}: r[1] = 1'b1;
          default: ;
        endcase
      7'h13: if (lo_rd && lo_s1 && (w[14:12] == 3'd0 || w[14:12] == 3'd4 ||
                                     w[14:12] == 3'd6 || w[14:12] == 3'd7)) r[2] = 1'b1;
      7'h03: if (lo_rd && lo_s1 && w[14:12] <= 3'd2) r[3] = 1'b1;
      default: ;
    endcase
    r[0] = (w == 32'h0000_0013);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] w);
    logic [3:0] e;
    logic nv;
    @(negedge clk_i);
    instr_i = w;
    #1;
    e = exp_types(w);
    chk(req, {28'd0, type_ok_o}, {28'd0, e});
    chk({req, "/R7"}, {31'd0, legal_o}, {31'd0, |e});
    nv = exp_viol | ~(|e);
    @(posedge clk_i);
    #1;
    chk("R8", {31'd0, viol_o}, {31'd0, nv});
    exp_viol = nv;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    instr_i = 32'h0000_0013;
    @(negedge clk_i);
    chk("R8 reset", {31'd0, viol_o}, 32'd0);
    exp_viol = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk_i);
    do_reset();
    // R2 reg-reg class and its function alternatives
    apply("R2 add",      mk(7'h00, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33));
    apply("R2 sub",      mk(7'h20, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33));
    apply("R2 f3=100",   mk(7'h00, 5'd4, 5'd5, 3'd4, 5'd6, 7'h33));
    apply("R2 f3=110",   mk(7'h00, 5'd4, 5'd5, 3'd6, 5'd6, 7'h33));
    apply("R2 f3=111",   mk(7'h00, 5'd4, 5'd5, 3'd7, 5'd6, 7'h33));
    // R6 register halving on reg-reg
    apply("R6 rd=15",    mk(7'h00, 5'd15, 5'd15, 3'd0, 5'd15, 7'h33));
    // R3 reg-imm with full immediate (bits 24:20 beyond 15 are not a register)
    apply("R3 addi imm", mk(7'h7f, 5'd31, 5'd1, 3'd0, 5'd2, 7'h13));
    apply("R3 f3=100",   mk(7'h01, 5'd9, 5'd1, 3'd4, 5'd2, 7'h13));
    apply("R3 f3=110",   mk(7'h01, 5'd9, 5'd1, 3'd6, 5'd2, 7'h13));
    apply("R3 f3=111",   mk(7'h01, 5'd9, 5'd1, 3'd7, 5'd2, 7'h13));
    // R4 load alternatives
    apply("R4 f3=000",   mk(7'h05, 5'd7, 5'd3, 3'd0, 5'd4, 7'h03));
    apply("R4 f3=001",   mk(7'h05, 5'd7, 5'd3, 3'd1, 5'd4, 7'h03));
    apply("R4 f3=010",   mk(7'h05, 5'd7, 5'd3, 3'd2, 5'd4, 7'h03));
    // R5 no-op word, and a near miss
    apply("R5 nop",      32'h0000_0013);
    apply("R5 addi 1",   32'h0010_0013);
    chk("R8 still clear", {31'd0, viol_o}, 32'd0);
    // illegal cases: violation sets and sticks (R8)
    apply("R2 sub f3=111", mk(7'h20, 5'd3, 5'd2, 3'd7, 5'd1, 7'h33));
    apply("R2 f3=001",   mk(7'h00, 5'd3, 5'd2, 3'd1, 5'd1, 7'h33));
    apply("R6 rd=16",    mk(7'h00, 5'd3, 5'd2, 3'd0, 5'd16, 7'h33));
    apply("R6 rs2=17",   mk(7'h00, 5'd17, 5'd2, 3'd0, 5'd1, 7'h33));
    apply("R6 rs1=31",   mk(7'h00, 5'd3, 5'd31, 3'd0, 5'd1, 7'h33));
    apply("R3 f3=001",   mk(7'h00, 5'd0, 5'd1, 3'd1, 5'd2, 7'h13));
    apply("R6 ri rd=20", mk(7'h00, 5'd0, 5'd1, 3'd0, 5'd20, 7'h13));
    apply("R4 f3=011",   mk(7'h00, 5'd0, 5'd1, 3'd3, 5'd2, 7'h03));
    apply("R6 ld rs1=20", mk(7'h00, 5'd0, 5'd20, 3'd0, 5'd2, 7'h03));
    apply("R7 unknown",  mk(7'h00, 5'd0, 5'd0, 3'd0, 5'd1, 7'h6f));
    apply("R8 legal after", 32'h0000_0013);
    do_reset();
    apply("R8 after reset", mk(7'h00, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33));
    // constrained random mix, R9 exclusivity via model
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      int k;
      w = $urandom;
      k = $urandom % 4;
      if (k == 0) w[6:0] = 7'h33;
      else if (k == 1) w[6:0] = 7'h13;
      else if (k == 2) w[6:0] = 7'h03;
      if ($urandom % 2 == 0) begin w[11] = 1'b0; w[19] = 1'b0; w[24] = 1'b0; end
      k = $urandom % 3;
      if (k == 0) w[31:25] = 7'h00;
      else if (k == 1) w[31:25] = 7'h20;
      if (i % 500 == 0) do_reset();
      apply("R9 random", w);
      chk("R9 exclusive", {31'd0, $countones(type_ok_o[3:1]) <= 1}, 32'd1);
    end
    summary();
  end
endmodule